// File: doc/BRIEF.md
# Companding Successive-Approximation Converter Sequencer

This block is the digital half of a successive-approximation converter. It works with an external DAC and an external comparator. Each frame strobe starts one conversion. The conversion begins with an autozero interval for the comparator. A sign trial follows, then a bit-by-bit search over seven magnitude bits. While the search runs, the block drives the trial code to the DAC and reads the comparator's decision back. When the last bit is decided, it publishes an 8-bit result word and pulses a completion flag.

In the default mode the magnitude is split into two fields. A 3-bit chord selects a binary-weighted segment. A 4-bit step selects a linear level inside that segment. The stored word is the bitwise inverse of sign, chord and step. A configuration bit switches the word to plain 8-bit linear (sign plus magnitude). A 2-bit input-mode field can route the converter to a supply-monitor input. In that mode the sign trial is skipped, the output is always linear, and bit 7 is zero. The DAC and comparator are scaled so that magnitude 0x7F corresponds to 6.3 V.

The DAC reads `dac_code_o` as {sign, magnitude}. In the default mode the magnitude is {chord[2:0], step[3:0]}, and the DAC's level is ((16+step)<<chord)-16. When `dac_lin_o` is high, the level is simply the magnitude.

Top module: `sar_companding_adc`

## Requirements
- R1: A high `frame_i` sampled while idle starts a conversion. `done_o` rises AZ_CYC+8 clock edges after that sampling edge on the signal path, and AZ_CYC+7 edges after it in supply-monitor mode.
- R2: Each conversion opens with `az_o` high for exactly AZ_CYC consecutive cycles. `dac_code_o` is zero whenever `az_o` is high.
- R3: On the signal path, one sign trial follows autozero with `dac_code_o` equal to zero. A comparator value of 1 means the input is at or above zero, and the sign bit is set to 1.
- R4: The magnitude trials decide bit 6 down to bit 0 in that order: chord bits first, then step bits, each MSB first. Each trial sets the current bit on top of the bits already kept, and keeps it when `cmp_i` is 1. The result is the largest code whose DAC level does not exceed the input magnitude.
- R5: In companded mode (`lin_i`=0, signal path), `word_o` is the bitwise inverse of {sign, chord[2:0], step[3:0]}.
- R6: With `lin_i`=1 on the signal path, `word_o` is {sign, magnitude[6:0]} without inversion, and `dac_lin_o` is 1 during the conversion.
- R7: `mode_i`=2'b10 selects the supply monitor. In that mode `path_sel_o` is 1, the output is linear whatever `lin_i` is, and `word_o[7]` is 0. Its magnitude is floor(V·127/6.3 V), saturating at 0x7F.
- R8: `done_o` is high for exactly one cycle per conversion. `word_o` changes only on the edge that raises `done_o`.
- R9: A `frame_i` pulse during a conversion is ignored. A pulse in the cycle where `done_o` is high starts the next conversion.
- R10: Synchronous active-low reset clears `word_o`, `done_o`, `az_o`, `dac_code_o` and `path_sel_o` to zero.
- R11: `lin_i` and `mode_i` are captured on the starting edge. Changing them mid-conversion does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | Frame strobe that starts a conversion |
| lin_i | input | 1 | 1 selects linear output, 0 selects companded output |
| mode_i | input | 2 | Input-mode field; 2'b10 selects the supply monitor |
| cmp_i | input | 1 | Comparator decision; 1 means the input is beyond the trial level |
| dac_code_o | output | 8 | Trial code {sign, magnitude} sent to the DAC |
| dac_lin_o | output | 1 | Tells the DAC to read the magnitude as linear |
| path_sel_o | output | 1 | Analog mux select; 1 selects the supply input |
| az_o | output | 1 | Comparator autozero enable |
| word_o | output | 8 | Result word, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two events that can share a cycle are the completion of one conversion and the frame strobe that opens the next. The bench watches for `done_o` at a falling edge and raises `frame_i` in that same cycle. It then expects a second result whose arrival cycle, counted from that strobe, matches the R1 latency exactly. It also checks that the first result was not disturbed. A strobe placed inside a running conversion must produce no extra completion, and any unmatched `done_o` counts as a failure.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AZ   = 2'd1,
        ST_SIGN = 2'd2,
        ST_MAG  = 2'd3
    } sar_st_e;
endpackage

// File: rtl/sar_ctrl.sv
// Phase controller: idle, autozero, sign trial and magnitude trials.
// Assumes frame_i is a synchronous strobe. Configuration is captured on the start edge.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int         AZ_CYC   = 4,
    parameter int         MAG_W    = 7,
    parameter logic [1:0] MON_CODE = 2'b10,
    localparam int        CW       = (AZ_CYC > 1) ? $clog2(AZ_CYC) : 1,
    localparam int        IW       = $clog2(MAG_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          lin_i,
    input  logic [1:0]    mode_i,
    output logic          start_o,
    output logic          az_o,
    output logic          sign_ph_o,
    output logic          mag_ph_o,
    output logic          last_o,
    output logic [IW-1:0] idx_o,
    output logic          lin_q_o,
    output logic          mon_q_o
);
    sar_st_e       state_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;

    // Decode phase flags from the current state.
    always_comb begin
        start_o   = (state_q == ST_IDLE) && frame_i;
        az_o      = (state_q == ST_AZ);
        sign_ph_o = (state_q == ST_SIGN);
        mag_ph_o  = (state_q == ST_MAG);
        last_o    = mag_ph_o && (idx_q == '0);
        idx_o     = idx_q;
    end

    // Step through the phases and capture the configuration at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            lin_q_o <= 1'b0;
            mon_q_o <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (frame_i) begin
                    state_q <= ST_AZ;
                    cnt_q   <= CW'(AZ_CYC - 1);
                    lin_q_o <= lin_i;
                    mon_q_o <= (mode_i == MON_CODE);
                end
                ST_AZ: begin
                    if (cnt_q == '0) begin
                        state_q <= mon_q_o ? ST_MAG : ST_SIGN;
                        idx_q   <= IW'(MAG_W - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SIGN: state_q <= ST_MAG;
                default: begin
                    if (idx_q == '0) state_q <= ST_IDLE;
                    else             idx_q   <= idx_q - 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sar_reg.sv
// Approximation register: holds the sign and the magnitude bits decided so far.
// Assumes cmp_i answers the trial code presented in the same cycle.
module sar_reg #(
    parameter  int MAG_W = 7,
    localparam int IW    = $clog2(MAG_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          sign_ph_i,
    input  logic          mag_ph_i,
    input  logic [IW-1:0] idx_i,
    input  logic          cmp_i,
    output logic          sign_o,
    output logic [MAG_W-1:0] mag_nx_o,
    output logic [MAG_W:0]   trial_o
);
    logic             sign_q;
    logic [MAG_W-1:0] mag_q;
    logic [MAG_W-1:0] bit_sel;
    logic [MAG_W-1:0] trial_mag;

    // Form the trial code and the magnitude after this decision.
    always_comb begin
        bit_sel   = MAG_W'(1) << idx_i;
        trial_mag = mag_q | bit_sel;
        mag_nx_o  = cmp_i ? trial_mag : mag_q;
        trial_o   = mag_ph_i ? {sign_q, trial_mag} : '0;
        sign_o    = sign_q;
    end

    // Clear at start, then record the sign and each kept bit.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            sign_q <= 1'b0;
            mag_q  <= '0;
        end else if (sign_ph_i) begin
            sign_q <= cmp_i;
        end else if (mag_ph_i) begin
            mag_q <= mag_nx_o;
        end
    end
endmodule

// File: rtl/sar_fmt.sv
// Output stage: formats the final code and raises the completion pulse.
// Assumes last_i is high for the single cycle of the final trial.
module sar_fmt #(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_i,
    input  logic             lin_i,
    input  logic             mon_i,
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W:0]   word_o,
    output logic             done_o
);
    logic [MAG_W:0] raw;

    // Select the layout for the finished word.
    always_comb begin
        raw = {sign_i, mag_i};
        if (mon_i)      raw = {1'b0, mag_i};
        else if (!lin_i) raw = ~raw;
    end

    // Load the word and pulse done on the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_i;
            if (last_i) word_o <= raw;
        end
    end
endmodule

// File: rtl/sar_companding_adc.sv
// Top of the companding successive-approximation sequencer.
// Assumes an external DAC and comparator answer combinationally within one cycle.
module sar_companding_adc #(
    parameter int         AZ_CYC   = 4,
    parameter int         CHORD_W  = 3,
    parameter int         STEP_W   = 4,
    parameter logic [1:0] MON_CODE = 2'b10,
    localparam int        MAG_W    = CHORD_W + STEP_W,
    localparam int        IW       = $clog2(MAG_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_i,
    input  logic           lin_i,
    input  logic [1:0]     mode_i,
    input  logic           cmp_i,
    output logic [MAG_W:0] dac_code_o,
    output logic           dac_lin_o,
    output logic           path_sel_o,
    output logic           az_o,
    output logic [MAG_W:0] word_o,
    output logic           done_o
);
    logic             start, sign_ph, mag_ph, last, lin_q, mon_q, sign;
    logic [IW-1:0]    idx;
    logic [MAG_W-1:0] mag_nx;

    sar_ctrl #(.AZ_CYC(AZ_CYC), .MAG_W(MAG_W), .MON_CODE(MON_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .lin_i(lin_i), .mode_i(mode_i),
        .start_o(start), .az_o(az_o), .sign_ph_o(sign_ph), .mag_ph_o(mag_ph),
        .last_o(last), .idx_o(idx), .lin_q_o(lin_q), .mon_q_o(mon_q)
    );

    sar_reg #(.MAG_W(MAG_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sign_ph_i(sign_ph),
        .mag_ph_i(mag_ph), .idx_i(idx), .cmp_i(cmp_i), .sign_o(sign),
        .mag_nx_o(mag_nx), .trial_o(dac_code_o)
    );

    sar_fmt #(.MAG_W(MAG_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .last_i(last), .lin_i(lin_q), .mon_i(mon_q),
        .sign_i(sign), .mag_i(mag_nx), .word_o(word_o), .done_o(done_o)
    );

    // Drive the analog-side controls from the captured configuration.
    always_comb begin
        dac_lin_o  = lin_q | mon_q;
        path_sel_o = mon_q;
    end
endmodule

// File: rtl/sar_companding_adc_chk.sv
// Property checker for the sequencer, attached through bind.
module sar_companding_adc_chk #(
    parameter int AZ_CYC = 4,
    parameter int W      = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         az_o,
    input logic         done_o,
    input logic         path_sel_o,
    input logic [W-1:0] dac_code_o,
    input logic [W-1:0] word_o
);
    logic [15:0] az_run;

    // Count the length of the current autozero run.
    always_ff @(posedge clk) begin
        if (!rst_n) az_run <= '0;
        else        az_run <= az_o ? az_run + 16'd1 : 16'd0;
    end

    a_r2_az_dac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        az_o |-> (dac_code_o == '0));
    a_r2_az_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(az_o) |-> (az_run == 16'(AZ_CYC)));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(word_o));
    a_r7_mon_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && path_sel_o) |-> (word_o[W-1] == 1'b0));
endmodule

bind sar_companding_adc sar_companding_adc_chk #(.AZ_CYC(AZ_CYC), .W(MAG_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .az_o(az_o), .done_o(done_o), .path_sel_o(path_sel_o),
    .dac_code_o(dac_code_o), .word_o(word_o)
);

// File: tb/tb_sar_companding_adc.sv
`timescale 1ns/1ps
module tb_sar_companding_adc;
    localparam int AZ = 4;

    typedef struct {
        logic [7:0] w;
        int         at;
        string      tag;
    } exp_t;

    logic       clk = 1'b0, rst_n = 1'b0, frame_i = 1'b0, lin_i = 1'b0, cmp_i;
    logic [1:0] mode_i = 2'b00;
    logic [7:0] dac_code_o, word_o;
    logic       dac_lin_o, path_sel_o, az_o, done_o;
    int         sig_x = 0, sup_mv = 0;
    int         cyc = 0, total = 0, bad = 0, az_cnt = 0;
    bit         ended = 0;
    exp_t       sb[$];

    sar_companding_adc #(.AZ_CYC(AZ)) dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .lin_i(lin_i), .mode_i(mode_i),
        .cmp_i(cmp_i), .dac_code_o(dac_code_o), .dac_lin_o(dac_lin_o),
        .path_sel_o(path_sel_o), .az_o(az_o), .word_o(word_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lvl(int code);
        return ((16 + (code & 15)) << (code >> 4)) - 16;
    endfunction

    // Analog model: DAC plus comparator.
    always_comb begin
        int c;
        c = int'(dac_code_o[6:0]);
        if (path_sel_o)      cmp_i = (sup_mv * 127 >= c * 6300);
        else if (c == 0)     cmp_i = (sig_x >= 0);
        else                 cmp_i = ((sig_x < 0 ? -sig_x : sig_x) >= (dac_lin_o ? c : lvl(c)));
    end

    function automatic logic [7:0] expect_w(int x, int mv, bit lin, logic [1:0] mode);
        int a, best, m;
        logic [7:0] w;
        if (mode == 2'b10) begin
            m = mv * 127 / 6300;
            if (m > 127) m = 127;
            return {1'b0, 7'(m)};
        end
        a = (x < 0) ? -x : x;
        best = 0;
        for (int c = 0; c < 128; c++) if ((lin ? c : lvl(c)) <= a) best = c;
        w = {(x >= 0), 7'(best)};
        return lin ? w : ~w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: call at a falling edge; pulses the strobe and pushes the expectation.
    task automatic launch(int x, int mv, bit lin, logic [1:0] mode, string tag);
        exp_t e;
        sig_x = x; sup_mv = mv; lin_i = lin; mode_i = mode; frame_i = 1'b1;
        e.w = expect_w(x, mv, lin, mode);
        e.at = cyc + AZ + ((mode == 2'b10) ? 8 : 9);
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        frame_i = 1'b0;
        lin_i = ~lin;                              // R11: change after capture
        mode_i = (mode == 2'b10) ? 2'b00 : 2'b10;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic conv(int x, int mv, bit lin, logic [1:0] mode, string tag);
        launch(x, mv, lin, mode, tag);
        drain();
    endtask

    // Monitor: pop and compare on each completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (az_o) begin
                az_cnt++;
                chk(dac_code_o == 8'h00, "R2 dac zero in autozero", dac_code_o, 0);
            end
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(word_o == e.w, e.tag, word_o, e.w);
                    chk(cyc == e.at, "R1 latency", cyc, e.at);
                    chk(az_cnt == AZ, "R2 autozero length", az_cnt, AZ);
                end
                az_cnt = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(word_o == 8'h00, "R10 word", word_o, 0);
        chk(done_o == 1'b0, "R10 done", done_o, 0);
        chk(az_o == 1'b0, "R10 az", az_o, 0);
        chk(dac_code_o == 8'h00, "R10 dac", dac_code_o, 0);
        chk(path_sel_o == 1'b0, "R10 path", path_sel_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: companded signal path
        conv(0,     0, 1'b0, 2'b00, "R3 R5 zero input");
        conv(1000,  0, 1'b0, 2'b00, "R4 R5 positive mid");
        conv(-37,   0, 1'b0, 2'b01, "R3 R4 negative small");
        conv(15,    0, 1'b0, 2'b00, "R4 chord0 top");
        conv(16,    0, 1'b0, 2'b00, "R4 chord1 base");
        conv(5000,  0, 1'b0, 2'b00, "R4 full scale clip");
        conv(-3000, 0, 1'b0, 2'b11, "R4 negative large");

        // R6: linear signal path
        conv(100,  0, 1'b1, 2'b00, "R6 linear positive");
        conv(-200, 0, 1'b1, 2'b00, "R6 linear negative clip");

        // R7: supply monitor
        conv(-500, 3150, 1'b0, 2'b10, "R7 monitor half scale");
        conv(-500, 6300, 1'b0, 2'b10, "R7 monitor full scale");
        conv(0,    0,    1'b1, 2'b10, "R7 monitor zero");
        conv(0,    7000, 1'b1, 2'b10, "R7 monitor saturate");

        // R9: strobe during a conversion is ignored
        launch(500, 0, 1'b0, 2'b00, "R9 busy strobe first");
        repeat (3) @(negedge clk);
        frame_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0;
        drain();

        // R9: strobe in the completion cycle starts the next conversion
        launch(222, 0, 1'b0, 2'b00, "R9 back to back first");
        while (!done_o) @(negedge clk);
        launch(-222, 0, 1'b1, 2'b00, "R9 back to back second");
        drain();

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule